// File: doc/BRIEF.md
# UART Dual Baud Timer Generator

This block derives the bit-rate strobes for a UART from one 8-bit auto-reload timer. A selectable count enable drives a transmit counter. Each time the counter passes 0xFF it loads a programmable reload byte again, so it overflows once every (256 − reload) counts. A toggle flop halves the overflow rate, and the result is a one-cycle transmit tick.

A second, private counter uses the same reload byte to time reception. When the receiver is idle and a falling edge arrives on the synchronized serial input, this counter jumps straight to the reload byte and its divide-by-two stage clears. Receive ticks therefore line up with the incoming start bit, whatever phase the transmit timer is in. A further start is accepted only after the receiving shift logic pulses `rx_done`.

The count enable comes from one of six sources: the system clock, three fixed prescalers, the external oscillator enable divided by eight, or an asynchronous count pin. The count pin is synchronized and counted on its rising edge. The resulting bit rate is f_count / (2 · (256 − reload)).

Top module: `uart_baud_gen`

## Requirements
- R1: The transmit counter (`tx_low`) advances by one per count enable. From 0xFF it loads `reload_val` as sampled at that overflow, so a reload change made mid-count does not alter the counts already under way.
- R2: `tx_tick` fires on every second transmit overflow. With a steady count enable every D cycles, ticks are D·2·(256 − reload) cycles apart, and `tx_low` equals the reload value in the cycle the tick is seen.
- R3: `clk_sel` encodes the count enable as follows. 0 is every cycle, 1 is every 4 cycles, 2 is every 12 cycles and 3 is every 48 cycles. 4 is every 8th cycle in which `ext_osc_en` is high. 5 is each synchronized rising edge of `ext_cnt_in`. Codes 6 and 7 give no count at all.
- R4: While `tmr_en` is low, both counters hold, both divide-by-two flops clear and no tick is produced. After re-enabling from a held count v with code 0, the first `tx_tick` appears 256 − v + (256 − reload) cycles later.
- R5: A falling edge on `rx_line` that reaches the receiver while it is idle force-loads the receive counter with the reload value and clears its divide-by-two flop. The edge passes two synchronizer flops and one edge register, and the force takes a further register. With code 0, `rx_tick` is therefore first seen 4 + 2·(256 − reload) cycles after `rx_line` falls.
- R6: After an accepted start, further falling edges on `rx_line` are ignored until `rx_done` is pulsed.
- R7: Receive ticks repeat with the same period as transmit ticks, and the start alignment of R5 holds at any transmit counter phase.
- R8: After reset `tx_low` is 0 and both ticks are low.
- R9: Each tick is a single-cycle pulse and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_osc_en | input | 1 | One-cycle enable per external oscillator period, in the clk domain |
| ext_cnt_in | input | 1 | Asynchronous external count pin |
| clk_sel | input | 3 | Count source select (encoding in R3) |
| tmr_en | input | 1 | Timer run enable |
| reload_val | input | 8 | Auto-reload byte shared by both counters |
| rx_line | input | 1 | Serial receive line, idle high |
| rx_done | input | 1 | Pulse from the receiver marking the end of a frame |
| tx_tick | output | 1 | Transmit bit-rate tick |
| rx_tick | output | 1 | Receive bit-rate tick |
| tx_low | output | 8 | Current transmit counter value |

## Verification
Some behaviours are checked by the assertions on every cycle. These are the transmit counter stepping by one or loading the previous reload byte after 0xFF, the silence and frozen count while the timer is disabled, the quiet state after reset, and the rule that a tick never lasts two cycles. The tick periods for each count source and reload value can only be shown by the bench's sweeps. So can the start-bit alignment latency at different transmit phases, the rejection of extra edges before `rx_done`, and the first-tick delay after re-enabling.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] CS_SYS    = 3'd0;
  localparam logic [SEL_W-1:0] CS_PRE_A  = 3'd1;
  localparam logic [SEL_W-1:0] CS_PRE_B  = 3'd2;
  localparam logic [SEL_W-1:0] CS_PRE_C  = 3'd3;
  localparam logic [SEL_W-1:0] CS_EXTOSC = 3'd4;
  localparam logic [SEL_W-1:0] CS_EXTPIN = 3'd5;
  localparam int unsigned N_PRE = 3;
  localparam int unsigned PRE_DIV [N_PRE] = '{4, 12, 48};
  localparam int unsigned EXTOSC_DIV = 8;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pulse
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign pulse = en && (cnt == LAST);
endmodule

// File: rtl/baud_src_select.sv
module baud_src_select
  import uart_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_osc_en,
  input  logic             ext_cnt_in,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             cnt_en
);
  logic [N_PRE-1:0] pre_pulse;
  logic             osc_pulse;
  logic [2:0]       pin_sync;
  logic             pin_rise;

  for (genvar g = 0; g < N_PRE; g++) begin : g_pre
    tick_divider #(.DIV(PRE_DIV[g])) u_div (
      .clk   (clk),
      .rst   (rst),
      .en    (1'b1),
      .pulse (pre_pulse[g])
    );
  end

  tick_divider #(.DIV(EXTOSC_DIV)) u_osc_div (
    .clk   (clk),
    .rst   (rst),
    .en    (ext_osc_en),
    .pulse (osc_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sync <= '0;
    end else begin
      pin_sync <= {pin_sync[1:0], ext_cnt_in};
    end
  end

  assign pin_rise = pin_sync[1] && !pin_sync[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_en <= 1'b0;
    end else begin
      case (clk_sel)
        CS_SYS:    cnt_en <= 1'b1;
        CS_PRE_A:  cnt_en <= pre_pulse[0];
        CS_PRE_B:  cnt_en <= pre_pulse[1];
        CS_PRE_C:  cnt_en <= pre_pulse[2];
        CS_EXTOSC: cnt_en <= osc_pulse;
        CS_EXTPIN: cnt_en <= pin_rise;
        default:   cnt_en <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/reload_counter.sv
module reload_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         cnt_en,
  input  logic         force_ld,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count,
  output logic         tick
);
  logic half;
  logic ovf;

  assign ovf = run && cnt_en && !force_ld && (count == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      half  <= 1'b0;
      tick  <= 1'b0;
    end else begin
      tick <= ovf && half;
      if (force_ld) begin
        count <= reload;
        half  <= 1'b0;
      end else if (!run) begin
        half  <= 1'b0;
      end else if (cnt_en) begin
        count <= ovf ? reload : count + 1'b1;
        if (ovf) half <= !half;
      end
    end
  end
endmodule

// File: rtl/rx_start_detect.sv
module rx_start_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_line,
  input  logic rx_done,
  output logic start
);
  logic [SYNC_STAGES-1:0] sync;
  logic prev;
  logic busy;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= '1;
      prev <= 1'b1;
    end else begin
      sync <= {sync[SYNC_STAGES-2:0], rx_line};
      prev <= sync[SYNC_STAGES-1];
    end
  end

  assign fall = prev && !sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= fall && !busy;
      if (rx_done)            busy <= 1'b0;
      else if (fall && !busy) busy <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_osc_en,
  input  logic             ext_cnt_in,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             tmr_en,
  input  logic [CW-1:0]    reload_val,
  input  logic             rx_line,
  input  logic             rx_done,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic [CW-1:0]    tx_low
);
  logic cnt_en;
  logic rx_start;
  logic [CW-1:0] rx_count;

  baud_src_select u_src (
    .clk        (clk),
    .rst        (rst),
    .ext_osc_en (ext_osc_en),
    .ext_cnt_in (ext_cnt_in),
    .clk_sel    (clk_sel),
    .cnt_en     (cnt_en)
  );

  rx_start_detect #(.SYNC_STAGES(2)) u_start (
    .clk     (clk),
    .rst     (rst),
    .rx_line (rx_line),
    .rx_done (rx_done),
    .start   (rx_start)
  );

  reload_counter #(.W(CW)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .run      (tmr_en),
    .cnt_en   (cnt_en),
    .force_ld (1'b0),
    .reload   (reload_val),
    .count    (tx_low),
    .tick     (tx_tick)
  );

  reload_counter #(.W(CW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .run      (tmr_en),
    .cnt_en   (cnt_en),
    .force_ld (rx_start),
    .reload   (reload_val),
    .count    (rx_count),
    .tick     (rx_tick)
  );

  logic unused_rx;
  assign unused_rx = ^rx_count;
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tmr_en,
  input logic [CW-1:0] reload_val,
  input logic          tx_tick,
  input logic          rx_tick,
  input logic [CW-1:0] tx_low
);
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (!$stable(tx_low) && $past(tx_low) != '1) |-> tx_low == $past(tx_low) + 1'b1);

  a_r1_reload: assert property (@(posedge clk) disable iff (rst)
    (!$stable(tx_low) && $past(tx_low) == '1) |-> tx_low == $past(reload_val));

  a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
    !tmr_en |=> (!tx_tick && !rx_tick && $stable(tx_low)));

  a_r8_reset: assert property (@(posedge clk)
    rst |=> (!tx_tick && !rx_tick && tx_low == '0));

  a_r9_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_tick |=> !tx_tick);

  a_r9_rx_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_tick |=> !rx_tick);
endmodule

bind uart_baud_gen uart_baud_gen_chk #(.CW(CW)) chk (
  .clk        (clk),
  .rst        (rst),
  .tmr_en     (tmr_en),
  .reload_val (reload_val),
  .tx_tick    (tx_tick),
  .rx_tick    (rx_tick),
  .tx_low     (tx_low)
);

// File: tb/tb_uart_baud_gen.sv
`timescale 1ns/1ps
module tb_uart_baud_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_osc_en = 1'b0;
  logic ext_cnt_in = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic tmr_en = 1'b0;
  logic [7:0] reload_val = 8'hF0;
  logic rx_line = 1'b1;
  logic rx_done = 1'b0;
  logic tx_tick, rx_tick;
  logic [7:0] tx_low;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  uart_baud_gen dut (
    .clk(clk), .rst(rst), .ext_osc_en(ext_osc_en), .ext_cnt_in(ext_cnt_in),
    .clk_sel(clk_sel), .tmr_en(tmr_en), .reload_val(reload_val),
    .rx_line(rx_line), .rx_done(rx_done),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .tx_low(tx_low)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // external stimulus: osc enable every other cycle, count pin period 6
  initial begin
    forever begin
      @(negedge clk); ext_osc_en = ~ext_osc_en;
    end
  end
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      ext_cnt_in = ~ext_cnt_in;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input bit rx, output int at);
    int guard = 0;
    at = -1;
    while (guard < 100000) begin
      @(negedge clk);
      if ((rx && rx_tick) || (!rx && tx_tick)) begin
        at = cyc;
        return;
      end
      guard++;
    end
  endtask

  // posedges from now until the selected tick is seen
  task automatic edges_to_tick(input bit rx, output int n);
    n = 0;
    while (n < 100000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if ((rx && rx_tick) || (!rx && tx_tick)) return;
    end
  endtask

  function automatic int src_div(input int s);
    case (s)
      0: return 1;
      1: return 4;
      2: return 12;
      3: return 48;
      4: return 16;
      default: return 6;
    endcase
  endfunction

  initial begin
    int t0, t1, n, p, v;
    int zero_ticks;
    logic [7:0] rl [4] = '{8'hFF, 8'hFE, 8'hFC, 8'hF0};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(tx_low == 8'd0 && !tx_tick && !rx_tick, "R8 reset", int'(tx_low), 0);

    // R2 R3 R7 R1: sweep of sources and reload values
    tmr_en = 1'b1;
    for (int s = 0; s < 6; s++) begin
      for (int k = 0; k < 4; k++) begin
        clk_sel = 3'(s);
        reload_val = rl[k];
        p = 256 - int'(rl[k]);
        repeat (3) wait_tick(1'b0, t0);
        wait_tick(1'b0, t1);
        check(t1 - t0 == src_div(s) * 2 * p, $sformatf("R2/R3 tx period sel%0d", s),
              t1 - t0, src_div(s) * 2 * p);
        check(tx_low == rl[k], "R1 reload value at tick", int'(tx_low), int'(rl[k]));
        wait_tick(1'b1, t0);
        wait_tick(1'b1, t1);
        check(t1 - t0 == src_div(s) * 2 * p, $sformatf("R7 rx period sel%0d", s),
              t1 - t0, src_div(s) * 2 * p);
      end
    end

    // R3 codes 6 and 7: no counting
    for (int s = 6; s < 8; s++) begin
      clk_sel = 3'(s);
      repeat (4) @(negedge clk);
      v = int'(tx_low);
      zero_ticks = 0;
      repeat (1500) begin
        @(negedge clk);
        if (tx_tick || rx_tick) zero_ticks++;
      end
      check(zero_ticks == 0 && int'(tx_low) == v, $sformatf("R3 idle code %0d", s),
            int'(tx_low), v);
    end

    // R1 mid-count reload change
    clk_sel = 3'd0;
    reload_val = 8'hF0;
    repeat (3) @(negedge clk);
    while (tx_low != 8'hF5) @(negedge clk);
    reload_val = 8'h80;
    repeat (10) @(negedge clk);
    check(tx_low == 8'hFF, "R1 count unaffected by write", int'(tx_low), 255);
    @(negedge clk);
    check(tx_low == 8'h80, "R1 new reload at overflow", int'(tx_low), 128);
    reload_val = 8'hF0;

    // R4 disable
    wait_tick(1'b0, t0);
    repeat (5) @(negedge clk);
    tmr_en = 1'b0;
    @(negedge clk);
    v = int'(tx_low);
    zero_ticks = 0;
    repeat (400) begin
      @(negedge clk);
      if (tx_tick || rx_tick) zero_ticks++;
    end
    check(zero_ticks == 0, "R4 no ticks when disabled", zero_ticks, 0);
    check(int'(tx_low) == v, "R4 count held", int'(tx_low), v);
    tmr_en = 1'b1;
    edges_to_tick(1'b0, n);
    check(n == 256 - v + 16, "R4 first tick after enable", n, 256 - v + 16);

    // R5 R7 start alignment at two different tx phases
    p = 16;
    for (int off = 0; off < 2; off++) begin
      wait_tick(1'b0, t0);
      repeat (3 + off * 7) @(negedge clk);
      rx_line = 1'b0;
      edges_to_tick(1'b1, n);
      check(n == 4 + 2 * p, $sformatf("R5/R7 start latency offset %0d", off), n, 4 + 2 * p);
      // R6: extra edge while busy is ignored
      rx_line = 1'b1;
      repeat (3) @(negedge clk);
      rx_line = 1'b0;
      edges_to_tick(1'b1, n);
      check(n == 2 * p - 3, "R6 extra edge ignored", n, 2 * p - 3);
      rx_line = 1'b1;
      rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0;
      repeat (5) @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule